// File: doc/BRIEF.md
# Serial Register Slave with Streamed Sample Dump

This block sits behind a four-wire serial port in clock mode 3 (clock idles high, data captured on the rising clock edge and changed on the falling edge, most significant bit first). It serves a bank of thirty-two 16-bit words that are addressed by byte. Each 16-bit frame holds a direction flag, a 6-bit byte address and one data byte. A read is pipelined, so the word it selects comes back on the shift output during the next frame. A write stores one byte into a configuration word and also sends that byte out on a one-cycle register-file port.

Words 1 to 11 hold sensor samples that arrive on a strobe port. Each of these words carries a fresh-sample flag, an alarm flag and a 14-bit value. Reading a word clears its fresh flag. A read of the command word (byte address 0x3E or 0x3F) starts a dump: the eleven sample words then stream out in address order, one per frame, while chip select stays low.

All port pins are brought into the system clock domain with a synchronizer. A small controller with three states runs the link. IDLE waits for chip select to fall; this is the IDLE to FRAME transition, and it reloads the pending response. FRAME collects 16 clocks and decodes the frame. It goes FRAME to IDLE when chip select rises, flagging an error if the frame was partial, and FRAME to BURST when a command-word read completes. BURST ignores the input data and loads the next sample word on each completed frame. It goes BURST to FRAME after the eleventh word, and BURST to IDLE when chip select rises.

Top module: `spi_reg_slave`

## Requirements
- R1: The port is clock mode 3, MSB first. Input data is captured on rising clock edges, the output changes on falling edges after the first, and a frame is exactly 16 rising edges while chip select is low.
- R2: In a frame, bit 15 set means write, bits 13:8 are the byte address and bits 7:0 are the data byte. Bit 14 is ignored.
- R3: A read frame makes the addressed word the output of the next frame. An odd byte address returns the 16-bit word that contains it. After reset or after a write frame, the next frame outputs 0x0000.
- R4: A write to byte address A at or above 0x18 stores its byte in the high half of word A/2 when A is odd and in the low half when A is even. It also raises cfg_we for one cycle with cfg_addr = A and cfg_data = the byte. Words 0x18 to 0x3C (bytes) can be read back.
- R5: Writes to byte addresses below 0x18 are ignored: nothing is stored and cfg_we stays low. Word 0 and the command word read as 0x0000.
- R6: Sample index k (0 to 10) is stored in word k+1 (byte address 2k+2). That word reads as bit 15 = fresh flag, bit 14 = alarm, bits 13:0 = sample value.
- R7: A sample strobe sets the word's fresh flag. A read clears it. The returned word shows the flag as it was before the read.
- R8: A read of byte address 0x3E or 0x3F starts a dump. The next eleven frames in the same chip select output words 1 to 11 in order and clear their fresh flags, and their input data is ignored. After the eleventh, the next frame outputs 0x0000. Chip select rising ends a dump early.
- R9: Chip select may stay low with the clock idle between two 8-bit halves of one frame.
- R10: If chip select rises after 1 to 15 clocks of a frame outside a dump, the frame is discarded: nothing is written and the pending response is kept. spi_err is then set and stays set until reset. A partial frame inside a dump does not set spi_err.
- R11: After reset spi_miso is 0, spi_err is 0, cfg_we is 0, and all fresh flags and stored bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| smp_we | input | 1 | Sample update strobe |
| smp_idx | input | 4 | Sample index 0 to 10 |
| smp_data | input | 14 | Sample value |
| smp_alarm | input | 1 | Alarm flag stored with the sample |
| cfg_we | output | 1 | One-cycle byte write pulse |
| cfg_addr | output | 6 | Byte address of the write |
| cfg_data | output | 8 | Byte written |
| spi_err | output | 1 | Sticky partial-frame error |

## Verification
The hardest case to reach from the ports is chip select rising in the middle of a word. Outside a dump this must discard the frame and set the error. Inside a dump it must end the dump quietly. The bench shifts a chosen number of bits, so it can stop after eight clocks in both states. It then reads back through a full frame to show that the pending response survived and the error flag behaved as required. A dump is also checked by feeding it a write-shaped input word, and later reading the target byte to confirm that it was not changed.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int FRAME_BITS = 16;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int WORD_IDX_W = ADDR_W - 1;
    localparam int NUM_WORDS  = 1 << WORD_IDX_W;
    localparam int OUT_FIRST  = 1;
    localparam int NUM_OUT    = 11;
    localparam int OUT_IDX_W  = $clog2(NUM_OUT);
    localparam int CFG_FIRST  = OUT_FIRST + NUM_OUT;
    localparam int CMD_WORD   = NUM_WORDS - 1;
    localparam int NUM_CFG    = CMD_WORD - CFG_FIRST;
    localparam int SAMPLE_W   = 14;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [ADDR_W-1:0] CFG_BYTE_BASE = ADDR_W'(2 * CFG_FIRST);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_BURST
    } link_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int STAGES = 2,
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/srs_shifter.sv
module srs_shifter
    import srs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  en,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  mosi,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    output logic [FRAME_BITS-2:0] rx_cmd,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic                  done,
    output logic                  miso
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] rx_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= '0;
            tx_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (en && sclk_rise) begin
                rx_q   <= {rx_q[FRAME_BITS-2:0], mosi};
                cnt_q  <= (cnt_q == LAST_BIT) ? '0 : cnt_q + CNT_W'(1);
                done_q <= (cnt_q == LAST_BIT);
            end
            if (load) begin
                tx_q <= load_word;
            end else if (en && sclk_fall && cnt_q != '0) begin
                tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // the bit below the flag is reserved and dropped here
    assign rx_cmd  = {rx_q[FRAME_BITS-1], rx_q[FRAME_BITS-3:0]};
    assign bit_cnt = cnt_q;
    assign done    = done_q;
    assign miso    = tx_q[FRAME_BITS-1];
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank
    import srs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_we,
    input  logic [OUT_IDX_W-1:0]  smp_idx,
    input  logic [SAMPLE_W-1:0]   smp_data,
    input  logic                  smp_alarm,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  clr_en,
    input  logic [WORD_IDX_W-1:0] clr_idx,
    input  logic [WORD_IDX_W-1:0] rd_idx,
    output logic [FRAME_BITS-1:0] rd_word
);
    logic [FRAME_BITS-1:0] out_word [NUM_OUT];
    logic [FRAME_BITS-1:0] cfg_word [NUM_CFG];

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        localparam logic [WORD_IDX_W-1:0] MY_IDX = WORD_IDX_W'(OUT_FIRST + o);
        logic                nd_q;
        logic                al_q;
        logic [SAMPLE_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                nd_q  <= 1'b0;
                al_q  <= 1'b0;
                val_q <= '0;
            end else begin
                if (clr_en && clr_idx == MY_IDX) nd_q <= 1'b0;
                if (smp_we && smp_idx == OUT_IDX_W'(o)) begin
                    nd_q  <= 1'b1;
                    al_q  <= smp_alarm;
                    val_q <= smp_data;
                end
            end
        end
        assign out_word[o] = {nd_q, al_q, val_q};
    end

    for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
        localparam logic [WORD_IDX_W-1:0] MY_IDX = WORD_IDX_W'(CFG_FIRST + c);
        logic [FRAME_BITS-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && wr_addr[ADDR_W-1:1] == MY_IDX) begin
                if (wr_addr[0]) word_q[FRAME_BITS-1:BYTE_W] <= wr_data;
                else            word_q[BYTE_W-1:0]          <= wr_data;
            end
        end
        assign cfg_word[c] = word_q;
    end

    always_comb begin
        rd_word = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (rd_idx == WORD_IDX_W'(OUT_FIRST + o)) rd_word = out_word[o];
        end
        for (int c = 0; c < NUM_CFG; c++) begin
            if (rd_idx == WORD_IDX_W'(CFG_FIRST + c)) rd_word = cfg_word[c];
        end
    end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import srs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic                 smp_we,
    input  logic [OUT_IDX_W-1:0] smp_idx,
    input  logic [SAMPLE_W-1:0]  smp_data,
    input  logic                 smp_alarm,
    output logic                 cfg_we,
    output logic [ADDR_W-1:0]    cfg_addr,
    output logic [BYTE_W-1:0]    cfg_data,
    output logic                 spi_err
);
    localparam logic [WORD_IDX_W-1:0] OUT_LO     = WORD_IDX_W'(OUT_FIRST);
    localparam logic [WORD_IDX_W-1:0] CMD_IDX    = WORD_IDX_W'(CMD_WORD);
    localparam logic [OUT_IDX_W-1:0]  LAST_BURST = OUT_IDX_W'(NUM_OUT - 1);

    // pin synchronizer and edge detection
    logic [2:0] pins_s;
    logic       sclk_d, cs_d;
    logic       sclk_rise, sclk_fall, cs_rise, cs_fall;

    srs_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_mosi, spi_cs_n, spi_sclk}),
        .q     (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= pins_s[0];
            cs_d   <= pins_s[1];
        end
    end

    assign sclk_rise = pins_s[0] & ~sclk_d;
    assign sclk_fall = ~pins_s[0] & sclk_d;
    assign cs_rise   = pins_s[1] & ~cs_d;
    assign cs_fall   = ~pins_s[1] & cs_d;

    // link state
    link_state_e           state_q, state_d;
    logic [OUT_IDX_W-1:0]  burst_q, burst_d;
    logic [FRAME_BITS-1:0] resp_q, resp_d;
    logic                  err_q;
    logic                  cfg_we_q;
    logic [ADDR_W-1:0]     cfg_addr_q;
    logic [BYTE_W-1:0]     cfg_data_q;

    // datapath between pieces
    logic [FRAME_BITS-2:0]  rx_cmd;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   done;
    logic                   load;
    logic [FRAME_BITS-1:0]  load_word;
    logic                   wr_en;
    logic                   clr_en;
    logic                   err_set;
    logic [WORD_IDX_W-1:0]  rd_idx;
    logic [FRAME_BITS-1:0]  rd_word;

    logic                   cmd_wr;
    logic [ADDR_W-1:0]      cmd_addr;
    logic [BYTE_W-1:0]      cmd_data;
    logic [WORD_IDX_W-1:0]  cmd_word;

    assign cmd_wr   = rx_cmd[FRAME_BITS-2];
    assign cmd_addr = rx_cmd[BYTE_W +: ADDR_W];
    assign cmd_data = rx_cmd[BYTE_W-1:0];
    assign cmd_word = cmd_addr[ADDR_W-1:1];

    srs_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_fall),
        .en        (state_q != ST_IDLE),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi      (pins_s[2]),
        .load      (load),
        .load_word (load_word),
        .rx_cmd    (rx_cmd),
        .bit_cnt   (bit_cnt),
        .done      (done),
        .miso      (spi_miso)
    );

    srs_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_we    (smp_we),
        .smp_idx   (smp_idx),
        .smp_data  (smp_data),
        .smp_alarm (smp_alarm),
        .wr_en     (wr_en),
        .wr_addr   (cmd_addr),
        .wr_data   (cmd_data),
        .clr_en    (clr_en),
        .clr_idx   (rd_idx),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            burst_q    <= '0;
            resp_q     <= '0;
            err_q      <= 1'b0;
            cfg_we_q   <= 1'b0;
            cfg_addr_q <= '0;
            cfg_data_q <= '0;
        end else begin
            state_q  <= state_d;
            burst_q  <= burst_d;
            resp_q   <= resp_d;
            cfg_we_q <= wr_en;
            if (err_set) err_q <= 1'b1;
            if (wr_en) begin
                cfg_addr_q <= cmd_addr;
                cfg_data_q <= cmd_data;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        burst_d   = burst_q;
        resp_d    = resp_q;
        load      = 1'b0;
        load_word = resp_q;
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        err_set   = 1'b0;
        rd_idx    = cmd_word;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) begin
                    state_d = ST_FRAME;
                    load    = 1'b1;
                end
            end
            ST_FRAME: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                    err_set = (bit_cnt != '0);
                end else if (done) begin
                    load = 1'b1;
                    if (cmd_wr) begin
                        wr_en     = (cmd_addr >= CFG_BYTE_BASE);
                        load_word = '0;
                    end else begin
                        if (cmd_word == CMD_IDX) begin
                            rd_idx  = OUT_LO;
                            state_d = ST_BURST;
                            burst_d = '0;
                        end
                        load_word = rd_word;
                        clr_en    = 1'b1;
                    end
                    resp_d = load_word;
                end
            end
            ST_BURST: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                end else if (done) begin
                    load = 1'b1;
                    if (burst_q == LAST_BURST) begin
                        state_d   = ST_FRAME;
                        load_word = '0;
                    end else begin
                        burst_d   = burst_q + OUT_IDX_W'(1);
                        rd_idx    = OUT_LO + WORD_IDX_W'(burst_q) + WORD_IDX_W'(1);
                        load_word = rd_word;
                        clr_en    = 1'b1;
                    end
                    resp_d = load_word;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cfg_we   = cfg_we_q;
    assign cfg_addr = cfg_addr_q;
    assign cfg_data = cfg_data_q;
    assign spi_err  = err_q;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import srs_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spi_err,
    input logic                 cfg_we,
    input logic [ADDR_W-1:0]    cfg_addr,
    input link_state_e          state_q,
    input logic [OUT_IDX_W-1:0] burst_q,
    input logic                 cs_rise,
    input logic                 cs_fall
);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err |=> spi_err);

    p_cfg_writable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> cfg_addr >= CFG_BYTE_BASE);

    p_cfg_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_we);

    p_burst_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST) |-> (burst_q <= OUT_IDX_W'(NUM_OUT - 1)));

    p_burst_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && cs_rise) |=> (state_q == ST_IDLE));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cs_fall) |=> (state_q == ST_IDLE));
endmodule

bind spi_reg_slave spi_reg_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_err  (spi_err),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .state_q  (state_q),
    .burst_q  (burst_q),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall)
);

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
    localparam int HALF  = 8;
    localparam int NVEC  = 16;

    // {frame sent, word expected back during that frame}
    localparam logic [31:0] VEC [NVEC] = '{
        32'hB6FF_0000, 32'hB7A5_0000, 32'h3600_0000, 32'h3700_A5FF,
        32'h0400_A5FF, 32'h0400_8B23, 32'h0000_0B23, 32'h9E1F_0000,
        32'h9FF6_0000, 32'h1E00_0000, 32'h0200_F61F, 32'h8A55_8A00,
        32'h4A00_0000, 32'h0000_8E8C, 32'h0200_0000, 32'h0000_0A00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        smp_we = 1'b0;
    logic [3:0]  smp_idx = '0;
    logic [13:0] smp_data = '0;
    logic        smp_alarm = 1'b0;
    logic        miso, cfg_we, spi_err;
    logic [5:0]  cfg_addr;
    logic [7:0]  cfg_data;

    int          checks = 0;
    int          errors = 0;
    int          cfg_cnt = 0;
    logic [5:0]  last_addr = '0;
    logic [7:0]  last_data = '0;
    logic [15:0] rx;

    always #2 clk = ~clk;

    spi_reg_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (sclk),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .smp_we    (smp_we),
        .smp_idx   (smp_idx),
        .smp_data  (smp_data),
        .smp_alarm (smp_alarm),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .spi_err   (spi_err)
    );

    always @(posedge clk) begin
        if (cfg_we) begin
            cfg_cnt   <= cfg_cnt + 1;
            last_addr <= cfg_addr;
            last_data <= cfg_data;
        end
    end

    function automatic logic [15:0] smp_val(int i);
        return 16'h0A00 + 16'(i) * 16'h0123;
    endfunction

    function automatic logic [15:0] out_exp(int i, bit nd);
        logic [15:0] v;
        v = smp_val(i);
        return {nd, (i == 3), v[13:0]};
    endfunction

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] tx, input int hi, input int lo,
                              inout logic [15:0] r);
        for (int b = hi; b >= lo; b--) begin
            sclk = 1'b0;
            mosi = tx[b];
            wait_half();
            r[b] = miso;
            sclk = 1'b1;
            wait_half();
        end
    endtask

    task automatic select();
        cs_n = 1'b0;
        wait_half();
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        wait_half();
        wait_half();
    endtask

    task automatic xfer(input logic [15:0] tx, output logic [15:0] r);
        logic [15:0] t;
        t = '0;
        shift_bits(tx, 15, 0, t);
        r = t;
    endtask

    task automatic single(input logic [15:0] tx, output logic [15:0] r);
        select();
        xfer(tx, r);
        deselect();
    endtask

    task automatic put_sample(int i);
        logic [15:0] v;
        v = smp_val(i);
        @(negedge clk);
        smp_we    = 1'b1;
        smp_idx   = 4'(i);
        smp_data  = v[13:0];
        smp_alarm = (i == 3);
        @(negedge clk);
        smp_we = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 reset state
        check16("R11 miso after reset", {15'b0, miso}, 16'h0000);
        check16("R11 spi_err after reset", {15'b0, spi_err}, 16'h0000);
        check16("R11 cfg_we after reset", {15'b0, cfg_we}, 16'h0000);

        for (int i = 0; i < 11; i++) put_sample(i);

        // vector walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] r;
            single(VEC[v][31:16], r);
            check16($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", v), r, VEC[v][15:0]);
        end

        // R4 register-file port, R5 read-only write produced no pulse
        check16("R4 R5 cfg pulse count", 16'(cfg_cnt), 16'd4);
        check16("R4 last cfg_addr", {10'b0, last_addr}, 16'h001F);
        check16("R4 last cfg_data", {8'b0, last_data}, 16'h00F6);

        // R8 full dump with a write-shaped word fed in mid-stream
        for (int i = 0; i < 11; i++) put_sample(i);
        select();
        xfer(16'h3E00, rx);
        for (int k = 0; k < 11; k++) begin
            logic [15:0] r;
            xfer((k == 5) ? 16'h9E00 : 16'h0000, r);
            check16($sformatf("R8 dump word %0d", k), r, out_exp(k, 1'b1));
        end
        xfer(16'h0000, rx);
        check16("R8 frame after dump", rx, 16'h0000);
        deselect();

        // R7 dump cleared the fresh flag
        single(16'h0200, rx);
        single(16'h0000, rx);
        check16("R7 flag cleared by dump", rx, out_exp(0, 1'b0));
        // R8 input data ignored during dump
        single(16'h1E00, rx);
        single(16'h0000, rx);
        check16("R8 dump ignored input", rx, 16'hF61F);
        check16("R8 no cfg pulse in dump", 16'(cfg_cnt), 16'd4);

        // R9 two 8-bit halves with an idle gap
        put_sample(1);
        select();
        rx = '0;
        shift_bits(16'h0400, 15, 8, rx);
        repeat (40) @(negedge clk);
        shift_bits(16'h0400, 7, 0, rx);
        xfer(16'h0000, rx);
        check16("R9 split frame read", rx, out_exp(1, 1'b1));
        deselect();

        // R8 dump ended early mid-word, R10 no error inside a dump
        select();
        xfer(16'h3E00, rx);
        xfer(16'h0000, rx);
        check16("R8 early-end dump first word", rx, out_exp(0, 1'b0));
        rx = '0;
        shift_bits(16'h0000, 15, 8, rx);
        deselect();
        check16("R10 no error on dump abort", {15'b0, spi_err}, 16'h0000);
        single(16'h0400, rx);
        single(16'h0000, rx);
        check16("R8 normal after abort", rx, out_exp(1, 1'b0));

        // R10 partial frame outside a dump
        put_sample(4);
        single(16'h0A00, rx);
        select();
        rx = '0;
        shift_bits(16'hB6AA, 15, 8, rx);
        deselect();
        check16("R10 spi_err set", {15'b0, spi_err}, 16'h0001);
        single(16'h0000, rx);
        check16("R10 response kept", rx, out_exp(4, 1'b1));
        check16("R10 no write from partial", 16'(cfg_cnt), 16'd4);
        single(16'h3600, rx);
        single(16'h0000, rx);
        check16("R10 stored word intact", rx, 16'hA5FF);
        check16("R10 spi_err sticky", {15'b0, spi_err}, 16'h0001);

        summary();
        $finish;
    end
endmodule